// File: doc/BRIEF.md
# Fractional M/N Clock Divider with Half-Step Pre-Divider

This block derives a slower clock from its input clock through two cascaded stages. A pre-divider removes whole or half steps of the input rate. An M/N accumulator stage then passes exactly m of every n pre-divided ticks. The result comes out in two forms. The first is a one-cycle clock-enable pulse train with an exact long-run ratio. The second is a level clock whose high time is set by a duty word.

The configuration arrives in the encoded register form used by the surrounding clock controller. M holds m directly. N holds the complement of (n - m). D holds the complement of the duty value. The block decodes these words and captures the configuration only on a load strobe. On that strobe both stages restart from zero, so a new ratio begins from a known phase.

Top module: `mnd_frac_div`

## Requirements
- R1: While rst_ni is low, clk_en_o and clk_o are 0.
- R2: On a cycle with load_i high, the block captures pre_div_i, mode_i, m_word_i, n_word_i and d_word_i. It clears both accumulators, and clk_en_o is 0 in the following cycle.
- R3: The decoded m equals m_word_i. The decoded n equals (~n_word_i + m_word_i) modulo 2^W.
- R4: When mode is 1 and n is non-zero, every window of P*n cycles after a load carries exactly p*min(m,n) pulses on clk_en_o. P and p are the pre-divider period and the pulse count defined in R7.
- R5: When mode is 0, or when the decoded n is 0, the M/N stage is bypassed and clk_en_o follows the pre-divider ticks.
- R6: With the M/N stage active, m = 0 gives no pulses. Any m >= n gives a pulse on every pre-divider tick.
- R7: A pre-divide field h of 0 or 1 gives a tick every cycle (P=1, p=1). A field h >= 2 gives exactly 2 ticks in every h+1 cycles (P=h+1, p=2).
- R8: Changes on the configuration inputs without load_i have no effect on the output pulse rate.
- R9: With the M/N stage active, h <= 1 and m = 1, clk_o is high for exactly min(d/2, n) of every n cycles, where d = (~d_word_i) modulo 2^W. In bypass, clk_o equals clk_en_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Strobe that captures the configuration and restarts both stages |
| pre_div_i | input | HW | Pre-divide field h |
| mode_i | input | 1 | Enables the M/N stage |
| m_word_i | input | W | Encoded M word |
| n_word_i | input | W | Encoded N word, the complement of (n - m) |
| d_word_i | input | W | Encoded D word, the complement of the duty value |
| clk_en_o | output | 1 | Divided clock-enable pulse |
| clk_o | output | 1 | Divided level clock |

## Verification
The bench uses the defaults W=8 and HW=5. Random cases draw n up to 40 and h up to 9, which keeps each full period below a few hundred cycles, so every case is checked over one complete window. The random cases also reach m above n, m of zero, n of zero with the mode bit set, and both pre-divider branches. Directed cases cover the duty output, the reset value, and inputs that change without a load.

// File: rtl/mnd_pkg.sv
package mnd_pkg;
  typedef enum logic {
    MN_BYPASS = 1'b0,
    MN_ACTIVE = 1'b1
  } mn_sel_e;
endpackage

// File: rtl/mnd_cfg_reg.sv
module mnd_cfg_reg
  import mnd_pkg::*;
#(
  parameter int W  = 8,
  parameter int HW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [HW-1:0] pre_div_i,
  input  logic          mode_i,
  input  logic [W-1:0]  m_word_i,
  input  logic [W-1:0]  n_word_i,
  input  logic [W-1:0]  d_word_i,
  output logic [HW-1:0] h_q_o,
  output mn_sel_e       sel_q_o,
  output logic [W-1:0]  m_q_o,
  output logic [W-1:0]  n_q_o,
  output logic [W-1:0]  d_q_o
);
  logic [W-1:0] n_dec, d_dec, m_eff;
  mn_sel_e      sel_dec;

  // n is stored as ~(n - m); recover it modulo 2^W
  assign n_dec   = ~n_word_i + m_word_i;
  assign d_dec   = ~d_word_i;
  assign sel_dec = (mode_i && n_dec != '0) ? MN_ACTIVE : MN_BYPASS;
  assign m_eff   = (m_word_i > n_dec) ? n_dec : m_word_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_q_o   <= '0;
      sel_q_o <= MN_BYPASS;
      m_q_o   <= '0;
      n_q_o   <= '0;
      d_q_o   <= '0;
    end else if (load_i) begin
      h_q_o   <= pre_div_i;
      sel_q_o <= sel_dec;
      m_q_o   <= m_eff;
      n_q_o   <= n_dec;
      d_q_o   <= d_dec;
    end
  end

  a_r3_active_needs_n: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_q_o == MN_ACTIVE) |-> (n_q_o != '0 && m_q_o <= n_q_o));
endmodule

// File: rtl/mnd_prediv.sv
module mnd_prediv #(
  parameter int HW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          restart_i,
  input  logic [HW-1:0] h_i,
  output logic          tick_o,
  output logic          pass_o
);
  localparam int AW = HW + 2;

  logic [AW-1:0] acc_q, div_w, sum_w;
  logic          wrap_w;

  assign pass_o = (h_i <= HW'(1));
  assign div_w  = AW'(h_i) + AW'(1);
  assign sum_w  = acc_q + AW'(2);
  assign wrap_w = (sum_w >= div_w);
  assign tick_o = pass_o | wrap_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             acc_q <= '0;
    else if (restart_i)      acc_q <= '0;
    else if (pass_o)         acc_q <= '0;
    else if (wrap_w)         acc_q <= sum_w - div_w;
    else                     acc_q <= sum_w;
  end

  a_r7_pre_acc_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pass_o |-> (acc_q < div_w));
endmodule

// File: rtl/mnd_mn_accum.sv
module mnd_mn_accum
  import mnd_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         restart_i,
  input  logic         tick_i,
  input  mn_sel_e      sel_i,
  input  logic [W-1:0] m_i,
  input  logic [W-1:0] n_i,
  input  logic [W-1:0] d_i,
  output logic         fire_o,
  output logic         level_o
);
  logic [W-1:0] acc_q;
  logic [W:0]   sum_w;
  logic         wrap_w;

  assign sum_w   = {1'b0, acc_q} + {1'b0, m_i};
  assign wrap_w  = (sum_w >= {1'b0, n_i});
  assign fire_o  = (sel_i == MN_ACTIVE) ? (tick_i & wrap_w) : tick_i;
  assign level_o = (acc_q < (d_i >> 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              acc_q <= '0;
    else if (restart_i)                       acc_q <= '0;
    else if (tick_i && sel_i == MN_ACTIVE)    acc_q <= wrap_w ? W'(sum_w - {1'b0, n_i}) : sum_w[W-1:0];
  end

  a_r4_acc_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == MN_ACTIVE) |-> (acc_q < n_i));
  a_r4_acc_frozen_without_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !restart_i) |=> $stable(acc_q));
endmodule

// File: rtl/mnd_frac_div.sv
module mnd_frac_div
  import mnd_pkg::*;
#(
  parameter int W  = 8,
  parameter int HW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [HW-1:0] pre_div_i,
  input  logic          mode_i,
  input  logic [W-1:0]  m_word_i,
  input  logic [W-1:0]  n_word_i,
  input  logic [W-1:0]  d_word_i,
  output logic          clk_en_o,
  output logic          clk_o
);
  logic [HW-1:0] h_q;
  mn_sel_e       sel_q;
  logic [W-1:0]  m_q, n_q, d_q;
  logic          tick_w, pass_w, fire_w, level_w, en_q;

  mnd_cfg_reg #(.W(W), .HW(HW)) u_cfg (
    .clk_i, .rst_ni, .load_i, .pre_div_i, .mode_i,
    .m_word_i, .n_word_i, .d_word_i,
    .h_q_o(h_q), .sel_q_o(sel_q), .m_q_o(m_q), .n_q_o(n_q), .d_q_o(d_q)
  );

  mnd_prediv #(.HW(HW)) u_pre (
    .clk_i, .rst_ni, .restart_i(load_i), .h_i(h_q),
    .tick_o(tick_w), .pass_o(pass_w)
  );

  mnd_mn_accum #(.W(W)) u_mn (
    .clk_i, .rst_ni, .restart_i(load_i), .tick_i(tick_w), .sel_i(sel_q),
    .m_i(m_q), .n_i(n_q), .d_i(d_q), .fire_o(fire_w), .level_o(level_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      en_q <= 1'b0;
    else if (load_i)  en_q <= 1'b0;
    else              en_q <= fire_w;
  end

  assign clk_en_o = en_q;
  assign clk_o    = (sel_q == MN_ACTIVE) ? level_w : en_q;

  a_r2_quiet_after_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> !clk_en_o);
  a_r5_bypass_every_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_q == MN_BYPASS && pass_w && !load_i) |=> clk_en_o);
  a_r6_zero_m_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_q == MN_ACTIVE && m_q == '0 && !load_i) |=> !clk_en_o);
  a_r9_bypass_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_q == MN_BYPASS) |-> (clk_o == clk_en_o));
  a_r1_reset_low: assert property (@(posedge clk_i) !rst_ni |-> (!clk_en_o && !clk_o));
endmodule

// File: tb/sim_mnd_frac_div.sv
module sim_mnd_frac_div;
  localparam int W  = 8;
  localparam int HW = 5;
  localparam int CLK_PERIOD = 10;

  logic          clk = 1'b0, rst_n = 1'b0, load = 1'b0, mode = 1'b0;
  logic [HW-1:0] pre = '0;
  logic [W-1:0]  mw = '0, nw = '0, dw = '0;
  logic          en, lvl;
  int            n_run = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mnd_frac_div #(.W(W), .HW(HW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load), .pre_div_i(pre), .mode_i(mode),
    .m_word_i(mw), .n_word_i(nw), .d_word_i(dw), .clk_en_o(en), .clk_o(lvl)
  );

  function automatic int pre_period(int h); return (h <= 1) ? 1 : h + 1; endfunction
  function automatic int pre_pulses(int h); return (h <= 1) ? 1 : 2;     endfunction
  function automatic int min2(int a, int b); return (a < b) ? a : b;     endfunction

  task automatic check(string req, int got, int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // true values are encoded the way the register words expect
  task automatic load_cfg(int h, bit md, int m, int n, int d);
    @(negedge clk);
    pre  = HW'(h);
    mode = md;
    mw   = W'(m);
    nw   = ~W'(n - m);
    dw   = ~W'(d);
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    check("R2 quiet after load", int'(en), 0);
  endtask

  task automatic measure(int len, output int pulses, output int highs);
    pulses = 0;
    highs  = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      pulses += int'(en);
      highs  += int'(lvl);
    end
  endtask

  task automatic run_case(string req, int h, bit md, int m, int n);
    int act, len, exp, p, hi;
    act = (md && (n % (1 << W)) != 0) ? 1 : 0;
    if (act != 0) begin
      len = pre_period(h) * n;
      exp = pre_pulses(h) * min2(m, n);
    end else begin
      len = pre_period(h) * 4;
      exp = pre_pulses(h) * 4;
    end
    load_cfg(h, md, m, n, n);
    measure(len, p, hi);
    check(req, p, exp);
  endtask

  initial begin
    int p, hi;
    void'($urandom(32'd2718));

    repeat (3) @(negedge clk);
    check("R1 reset en", int'(en), 0);
    check("R1 reset clk_o", int'(lvl), 0);
    rst_n = 1'b1;

    // R4 / R3: plain ratios through the encoded words
    run_case("R4 3/7 h0", 0, 1'b1, 3, 7);
    run_case("R3 5/16 h1", 1, 1'b1, 5, 16);
    run_case("R4 11/13 h4", 4, 1'b1, 11, 13);
    // R7: half-step pre-division alone
    run_case("R7 h2 bypass", 2, 1'b0, 1, 1);
    run_case("R7 h5 bypass", 5, 1'b0, 1, 1);
    run_case("R7 h0 bypass", 0, 1'b0, 2, 9);
    // R5: n of zero with mode set is a bypass
    run_case("R5 n zero", 3, 1'b1, 4, 0);
    run_case("R5 mode off", 0, 1'b0, 3, 7);
    // R6: m edges
    run_case("R6 m zero", 0, 1'b1, 0, 9);
    run_case("R6 m above n", 2, 1'b1, 12, 6);
    run_case("R6 m equals n", 0, 1'b1, 8, 8);

    // R9: duty from the D word with m=1
    load_cfg(0, 1'b1, 1, 10, 6);
    measure(10, p, hi);
    check("R9 duty 6/10", hi, 3);
    load_cfg(1, 1'b1, 1, 12, 40);
    measure(12, p, hi);
    check("R9 duty clamp", hi, 12);
    load_cfg(3, 1'b0, 0, 0, 0);
    measure(8, p, hi);
    check("R9 bypass level", hi, p);

    // R8: input changes without a strobe are ignored
    load_cfg(0, 1'b1, 2, 9, 9);
    @(negedge clk);
    pre = HW'(7); mode = 1'b0; mw = 8'h55; nw = 8'h12; dw = 8'h00;
    measure(18, p, hi);
    check("R8 ignore inputs", p, 4);

    // random mix
    for (int k = 0; k < 40; k++) begin
      int h, m, n;
      bit md;
      h  = int'($urandom_range(0, 9));
      n  = int'($urandom_range(0, 40));
      m  = int'($urandom_range(0, n + 3));
      md = 1'($urandom_range(0, 3) != 0);
      run_case("R4 random", h, md, m, n);
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: got hang expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule